// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs burst reads against an external NOR flash or pseudo-static RAM over a synchronous bus. It makes the memory clock itself by dividing the system clock by a programmed ratio. Once a request has been accepted, it drives the address and chip select, pulses an active-low address-valid strobe around the first memory clock rising edge, and counts a programmed number of memory clock periods as initial latency. After that it captures one data beat on each rising memory clock edge for which the memory's wait input is low.

A requester presents an address, a beat count, a divide ratio, a latency and a turnaround length together with a start request, and it holds the request until the block shows it is ready. Captured beats come back as single-cycle valid pulses with data. When the last beat has been taken, chip select is released and the memory clock stops low. The block then waits a programmable number of turnaround cycles before it accepts the next request.

Top module: `sync_burst_reader`

## Requirements
- R1: While a burst runs, `mem_clk` repeats with a period of the clamped divide ratio D in system cycles. It is high for floor(D/2) cycles and low for the rest. `cfg_div` values below 2 act as 2 and values above 16 act as 16.
- R2: `mem_clk` is low in every cycle in which `mem_cs_n` is high.
- R3: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `mem_cs_n`, `mem_oe_n` and `mem_adv_n` are low and `mem_addr` shows `req_addr`. `mem_addr` then holds steady until `mem_cs_n` rises. After reset, `mem_cs_n`, `mem_oe_n` and `mem_adv_n` are high, and `mem_clk` and `rd_valid` are low.
- R4: `mem_adv_n` stays low for exactly D system cycles from the cycle in which `mem_cs_n` falls. The first rising edge of `mem_clk` lies inside that window, D - floor(D/2) cycles after chip select falls.
- R5: Number the rising `mem_clk` edges of a burst from 1, where edge 1 latches the address. The first beat is taken no earlier than edge L+1, with L being `cfg_lat` clamped to 2..17. With `mem_wait` low, the first `rd_valid` therefore comes (L+1)*D - floor(D/2) cycles after chip select falls.
- R6: A beat takes the value `mem_data` had in the system cycle just before the rising edge. `rd_valid` is high for one cycle, the cycle right after that edge, and `rd_data` carries the sampled value.
- R7: When `mem_wait` is high in the cycle before a data edge (edge L+1 or later), no beat is taken at that edge. During edges 1..L the value of `mem_wait` has no effect.
- R8: A burst delivers exactly `req_len` beats, with 0 taken as 1. `mem_cs_n` and `mem_oe_n` rise together with the last `rd_valid`. The rising edge that would have followed is suppressed, so `mem_clk` stays low.
- R9: After `mem_cs_n` rises, `req_ready` stays low for T cycles, where T is the `cfg_turn` value latched with the request. A request that is already waiting therefore sees `mem_cs_n` high for exactly T+1 cycles between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request, held until accepted |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | 26 | Start address of the burst |
| req_len | input | 8 | Number of beats (0 means 1) |
| cfg_div | input | 5 | System cycles per memory clock, clamped to 2..16 |
| cfg_lat | input | 5 | Initial latency in memory clocks, clamped to 2..17 |
| cfg_turn | input | 4 | Turnaround cycles after a burst |
| mem_clk | output | 1 | Memory clock |
| mem_addr | output | 26 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wait | input | 1 | Wait from the memory, high halts capture |
| mem_data | input | 16 | Read data from the memory |
| rd_valid | output | 1 | One-cycle pulse per captured beat |
| rd_data | output | 16 | Captured beat |

## Verification
The wait input and the latency count meet at the same memory clock edge, and so do the wait input and the final beat. A stall at the last beat must stretch the burst instead of ending it. The bench provokes the first case by holding `mem_wait` high through the whole latency and dropping it just before edge L+1; it judges the result by requiring the first beat to arrive on exactly the no-wait cycle. It provokes the second with pseudo-random wait patterns, which land on the final edge as well. The cycle model then requires chip select to rise only on the edge that actually captures the last beat, and requires the turnaround gap before a request that is already waiting to come out exactly T+1 cycles long.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_TURN  = 2'd2
  } sbr_state_e;

endpackage

// File: rtl/sbr_cfg_clamp.sv
module sbr_cfg_clamp #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 5,
  parameter int LO    = 2,
  parameter int HI    = 16
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] val
);

  localparam logic [IN_W-1:0] LO_IN = IN_W'(LO);
  localparam logic [IN_W-1:0] HI_IN = IN_W'(HI);

  always_comb begin
    if (raw < LO_IN) begin
      val = OUT_W'(LO);
    end else if (raw > HI_IN) begin
      val = OUT_W'(HI);
    end else begin
      val = OUT_W'(raw);
    end
  end

endmodule

// File: rtl/sbr_clkgen.sv
module sbr_clkgen #(
  parameter int DV_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            halt,
  input  logic [DV_W-1:0] div,
  output logic            mem_clk,
  output logic            rise_next,
  output logic            first_period_end
);

  logic [DV_W-1:0] div_q, div_d;
  logic [DV_W-1:0] hi_q, hi_d;
  logic [DV_W-1:0] cnt_q, cnt_d;
  logic            on_q, on_d;
  logic            clk_q, clk_d;
  logic            wrap;

  assign wrap             = (cnt_q == (div_q - DV_W'(1)));
  assign rise_next        = on_q & wrap;
  assign first_period_end = on_q & (cnt_q == (hi_q - DV_W'(1)));
  assign mem_clk          = clk_q;

  always_comb begin
    div_d = div_q;
    hi_d  = hi_q;
    cnt_d = cnt_q;
    on_d  = on_q;
    clk_d = clk_q;
    if (start) begin
      div_d = div;
      hi_d  = div >> 1;
      cnt_d = div >> 1;
      on_d  = 1'b1;
      clk_d = 1'b0;
    end else if (on_q) begin
      if (halt) begin
        on_d  = 1'b0;
        clk_d = 1'b0;
      end else begin
        cnt_d = wrap ? '0 : (cnt_q + DV_W'(1));
        clk_d = (cnt_d < hi_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
      on_q  <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      div_q <= div_d;
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
      on_q  <= on_d;
      clk_q <= clk_d;
    end
  end

endmodule

// File: rtl/sbr_beatctl.sv
module sbr_beatctl #(
  parameter int LT_W  = 5,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LT_W-1:0]  lat,
  input  logic [LEN_W-1:0] len,
  input  logic             rise_next,
  input  logic             mem_wait,
  output logic             capture,
  output logic             last
);

  logic [LT_W-1:0]  lat_left_q, lat_left_d;
  logic [LEN_W-1:0] beats_q, beats_d;
  logic             in_data;

  assign in_data = (lat_left_q == '0);
  assign capture = rise_next & in_data & ~mem_wait;
  assign last    = capture & (beats_q <= LEN_W'(1));

  always_comb begin
    lat_left_d = lat_left_q;
    beats_d    = beats_q;
    if (start) begin
      lat_left_d = lat;
      beats_d    = len;
    end else if (rise_next) begin
      if (!in_data) begin
        lat_left_d = lat_left_q - LT_W'(1);
      end else if (capture && (beats_q != '0)) begin
        beats_d = beats_q - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_left_q <= '0;
      beats_q    <= '0;
    end else begin
      lat_left_q <= lat_left_d;
      beats_q    <= beats_d;
    end
  end

endmodule

// File: rtl/sbr_turnctl.sv
module sbr_turnctl #(
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TURN_W-1:0] turn,
  input  logic              arm,
  input  logic              run,
  output logic              turn_zero,
  output logic              expire
);

  logic [TURN_W-1:0] turn_q, turn_d;
  logic [TURN_W-1:0] rem_q, rem_d;

  assign turn_zero = (turn_q == '0);
  assign expire    = (rem_q == TURN_W'(1));

  always_comb begin
    turn_d = turn_q;
    rem_d  = rem_q;
    if (load) begin
      turn_d = turn;
    end
    if (arm) begin
      rem_d = turn_q;
    end else if (run && (rem_q != '0)) begin
      rem_d = rem_q - TURN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= '0;
      rem_q  <= '0;
    end else begin
      turn_q <= turn_d;
      rem_q  <= rem_d;
    end
  end

endmodule

// File: rtl/sync_burst_reader.sv
module sync_burst_reader #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 8,
  parameter int DIV_W   = 5,
  parameter int LAT_W   = 5,
  parameter int TURN_W  = 4,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 16,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [TURN_W-1:0] cfg_turn,
  output logic              mem_clk,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  input  logic              mem_wait,
  input  logic [DATA_W-1:0] mem_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  import sbr_pkg::*;

  localparam int DV_W = $clog2(DIV_MAX + 1);
  localparam int LT_W = $clog2(LAT_MAX + 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  // clamped configuration
  logic [DV_W-1:0] div_c;
  logic [LT_W-1:0] lat_c;

  sbr_cfg_clamp #(.IN_W(DIV_W), .OUT_W(DV_W), .LO(DIV_MIN), .HI(DIV_MAX)) u_div_clamp (
    .raw (cfg_div),
    .val (div_c)
  );

  sbr_cfg_clamp #(.IN_W(LAT_W), .OUT_W(LT_W), .LO(LAT_MIN), .HI(LAT_MAX)) u_lat_clamp (
    .raw (cfg_lat),
    .val (lat_c)
  );

  // control state
  sbr_state_e        state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic              oe_n_q, oe_n_d;
  logic              adv_n_q, adv_n_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic accept;
  logic rise_next, first_period_end;
  logic capture, last;
  logic turn_zero, expire;

  assign req_ready = (state_q == ST_IDLE) & rst_i_n;
  assign accept    = req_valid & req_ready;

  sbr_clkgen #(.DV_W(DV_W)) u_clkgen (
    .clk              (clk),
    .rst_n            (rst_i_n),
    .start            (accept),
    .halt             (last),
    .div              (div_c),
    .mem_clk          (mem_clk),
    .rise_next        (rise_next),
    .first_period_end (first_period_end)
  );

  sbr_beatctl #(.LT_W(LT_W), .LEN_W(LEN_W)) u_beatctl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (accept),
    .lat       (lat_c),
    .len       (req_len),
    .rise_next (rise_next),
    .mem_wait  (mem_wait),
    .capture   (capture),
    .last      (last)
  );

  sbr_turnctl #(.TURN_W(TURN_W)) u_turnctl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (accept),
    .turn      (cfg_turn),
    .arm       (last),
    .run       (state_q == ST_TURN),
    .turn_zero (turn_zero),
    .expire    (expire)
  );

  always_comb begin
    state_d = state_q;
    cs_n_d  = cs_n_q;
    oe_n_d  = oe_n_q;
    adv_n_d = adv_n_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_BURST;
          cs_n_d  = 1'b0;
          oe_n_d  = 1'b0;
          adv_n_d = 1'b0;
          addr_d  = req_addr;
        end
      end
      ST_BURST: begin
        if (first_period_end) begin
          adv_n_d = 1'b1;
        end
        if (last) begin
          cs_n_d  = 1'b1;
          oe_n_d  = 1'b1;
          adv_n_d = 1'b1;
          state_d = turn_zero ? ST_IDLE : ST_TURN;
        end
      end
      ST_TURN: begin
        if (expire) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    vld_d  = capture;
    data_d = capture ? mem_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      adv_n_q <= 1'b1;
      addr_q  <= '0;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      oe_n_q  <= oe_n_d;
      adv_n_q <= adv_n_d;
      addr_q  <= addr_d;
      vld_q   <= vld_d;
      data_q  <= data_d;
    end
  end

  assign mem_cs_n  = cs_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_adv_n = adv_n_q;
  assign mem_addr  = addr_q;
  assign rd_valid  = vld_q;
  assign rd_data   = data_q;

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_clk,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_adv_n,
  input logic              mem_oe_n,
  input logic              rd_valid
);

  AST_CLK_QUIET_OFF_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> !mem_clk); // R2

  AST_ADV_WITHIN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n); // R4

  AST_CS_FALL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (!mem_adv_n && !mem_oe_n)); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R3

  AST_OE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n == mem_cs_n); // R8

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R9

  AST_BEAT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(mem_cs_n)); // R6

  AST_NO_CLK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> !mem_clk); // R8

endmodule

bind sync_burst_reader sbr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_clk   (mem_clk),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_adv_n (mem_adv_n),
  .mem_oe_n  (mem_oe_n),
  .rd_valid  (rd_valid)
);

// File: tb/sync_burst_reader_tb.sv
`timescale 1ns/1ps
module sync_burst_reader_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [25:0] req_addr;
  logic [7:0]  req_len;
  logic [4:0]  cfg_div;
  logic [4:0]  cfg_lat;
  logic [3:0]  cfg_turn;
  logic        mem_clk;
  logic [25:0] mem_addr;
  logic        mem_cs_n;
  logic        mem_adv_n;
  logic        mem_oe_n;
  logic        mem_wait;
  logic [15:0] mem_data;
  logic        rd_valid;
  logic [15:0] rd_data;

  int total;
  int bad;
  int cyc;
  logic model_on;
  logic [15:0] lfsr;

  sync_burst_reader u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .cfg_div   (cfg_div),
    .cfg_lat   (cfg_lat),
    .cfg_turn  (cfg_turn),
    .mem_clk   (mem_clk),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_oe_n  (mem_oe_n),
    .mem_wait  (mem_wait),
    .mem_data  (mem_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected <150000)", cyc);
      finish_run();
    end
  end

  always @(negedge clk) mem_data = 16'(cyc * 40503) ^ 16'h5a3c;

  function automatic int clamp_i(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state; // 0 idle, 1 burst, 2 turnaround
  int m_t, m_div, m_hi, m_lat, m_beats, m_cap, m_turn, m_tl;
  int m_addr;
  bit e_vld;
  int e_data;
  bit e_cs_n, e_adv_n, e_clk, e_ready;
  int exp_q[$];

  always @(posedge clk) begin
    if (model_on) begin
      e_vld = 1'b0;
      case (m_state)
        0: begin
          if (req_valid) begin
            m_div   = clamp_i(int'(cfg_div), 2, 16);
            m_hi    = m_div / 2;
            m_lat   = clamp_i(int'(cfg_lat), 2, 17);
            m_beats = (req_len == 0) ? 1 : int'(req_len);
            m_turn  = int'(cfg_turn);
            m_addr  = int'(req_addr);
            m_t     = 0;
            m_cap   = 0;
            m_state = 1;
          end
        end
        1: begin
          if (((m_t + m_hi) % m_div) == m_div - 1) begin
            if (((m_t + m_hi + 1) / m_div) > m_lat && !mem_wait) begin
              m_cap  = m_cap + 1;
              e_vld  = 1'b1;
              e_data = int'(mem_data);
              if (m_cap >= m_beats) begin
                m_tl    = m_turn;
                m_state = (m_turn == 0) ? 0 : 2;
              end
            end
          end
          if (m_state == 1) m_t = m_t + 1;
        end
        default: begin
          m_tl = m_tl - 1;
          if (m_tl == 0) m_state = 0;
        end
      endcase
      e_cs_n  = (m_state != 1);
      e_adv_n = !(m_state == 1 && m_t < m_div);
      e_clk   = (m_state == 1) && (((m_t + m_hi) % m_div) < m_hi);
      e_ready = (m_state == 0);
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(mem_clk === e_clk, "R1/R2 mem_clk", int'(mem_clk), int'(e_clk));
      chk(mem_cs_n === e_cs_n, "R3/R8 mem_cs_n", int'(mem_cs_n), int'(e_cs_n));
      chk(mem_oe_n === e_cs_n, "R8 mem_oe_n", int'(mem_oe_n), int'(e_cs_n));
      chk(mem_adv_n === e_adv_n, "R4 mem_adv_n", int'(mem_adv_n), int'(e_adv_n));
      chk(req_ready === e_ready, "R9 req_ready", int'(req_ready), int'(e_ready));
      chk(rd_valid === e_vld, "R5/R7 rd_valid", int'(rd_valid), int'(e_vld));
      if (e_vld && rd_valid) chk(int'(rd_data) == e_data, "R6 rd_data", int'(rd_data), e_data);
      if (!e_cs_n) chk(int'(mem_addr) == m_addr, "R3 mem_addr", int'(mem_addr), m_addr);
    end
  end

  // ---------------- stimulus ----------------
  int cs_high_run;
  int last_gap;

  always @(negedge clk) begin
    if (model_on) begin
      if (mem_cs_n) cs_high_run = cs_high_run + 1;
      else if (cs_high_run != 0) begin
        last_gap    = cs_high_run;
        cs_high_run = 0;
      end
    end
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic issue(input int addr, input int len, input int div, input int lat, input int turn);
    req_addr  = 26'(addr);
    req_len   = 8'(len);
    cfg_div   = 5'(div);
    cfg_lat   = 5'(lat);
    cfg_turn  = 4'(turn);
    req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    cfg_div   = 5'd9;
    cfg_lat   = 5'd9;
    cfg_turn  = 4'd9;
    req_len   = 8'd9;
  endtask

  // wmode: 0 none, 1 pseudo-random, 2 high through latency only
  task automatic run_burst(input int addr, input int len, input int div, input int lat,
                           input int turn, input int wmode);
    int d, l, n, first, t, beats;
    d = clamp_i(div, 2, 16);
    l = clamp_i(lat, 2, 17);
    beats = (len == 0) ? 1 : len;
    first = (l + 1) * d - d / 2;
    issue(addr, len, div, lat, turn);
    n = 0;
    t = 0;
    forever begin
      if (rd_valid) begin
        if (n == 0 && wmode != 1)
          chk(t == first, "R5 first beat cycle", t, first);
        n = n + 1;
      end
      if (req_ready) break;
      case (wmode)
        1: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          mem_wait = lfsr[0] & lfsr[3];
        end
        2: mem_wait = (t < first - 1);
        default: mem_wait = 1'b0;
      endcase
      @(negedge clk);
      t = t + 1;
    end
    mem_wait = 1'b0;
    chk(n == beats, "R8 beat count", n, beats);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0;
    model_on = 1'b0;
    lfsr = 16'hace1;
    cs_high_run = 0; last_gap = 0;
    m_state = 0; m_t = 0; m_div = 2; m_hi = 1; m_lat = 2; m_beats = 1;
    m_cap = 0; m_turn = 0; m_tl = 0; m_addr = 0;
    e_vld = 0; e_data = 0; e_cs_n = 1; e_adv_n = 1; e_clk = 0; e_ready = 1;
    req_valid = 0; req_addr = '0; req_len = '0;
    cfg_div = 5'd2; cfg_lat = 5'd2; cfg_turn = '0; mem_wait = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R3 reset state
    chk(mem_cs_n === 1'b1, "R3 reset cs_n", int'(mem_cs_n), 1);
    chk(mem_oe_n === 1'b1, "R3 reset oe_n", int'(mem_oe_n), 1);
    chk(mem_adv_n === 1'b1, "R3 reset adv_n", int'(mem_adv_n), 1);
    chk(mem_clk === 1'b0, "R2 reset mem_clk", int'(mem_clk), 0);
    chk(rd_valid === 1'b0, "R6 reset rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // R1 R4 R5 basic, smallest ratio
    run_burst(26'h0001234, 4, 2, 2, 0, 0);
    // R1 odd ratio, R7 random wait
    run_burst(26'h3ffffff, 3, 3, 3, 2, 1);
    // R7 wait held through latency is ignored
    run_burst(26'h0abcdef, 5, 4, 2, 1, 2);
    run_burst(26'h1555555, 6, 5, 4, 3, 1);
    // R5 largest ratio and latency
    run_burst(26'h2000000, 2, 16, 17, 0, 0);
    run_burst(26'h0000007, 8, 7, 2, 0, 1);
    // R1 R5 R8 clamping and zero length
    run_burst(26'h0000100, 0, 0, 31, 1, 0);
    run_burst(26'h0000200, 3, 31, 0, 0, 2);
    run_burst(26'h0000300, 2, 1, 1, 0, 0);

    // R9 back-to-back gaps
    run_burst(26'h0011111, 2, 3, 2, 3, 0);
    run_burst(26'h0022222, 2, 3, 2, 0, 0);
    chk(last_gap == 4, "R9 gap after turn=3", last_gap, 4);
    run_burst(26'h0033333, 3, 2, 3, 0, 1);
    chk(last_gap == 1, "R9 gap after turn=0", last_gap, 1);
    run_burst(26'h0044444, 1, 6, 5, 15, 1);
    run_burst(26'h0055555, 4, 6, 5, 0, 1);
    chk(last_gap == 16, "R9 gap after turn=15", last_gap, 16);

    // long random-wait bursts, odd and even ratios
    for (int i = 0; i < 6; i++) begin
      run_burst(26'h100000 + i * 64, 10 + i, 2 + 3 * i, 2 + 2 * i, i, 1);
    end

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 queue empty", exp_q.size(), 0);
    finish_run();
  end

endmodule